// File: doc/BRIEF.md
# Real-Time Clock Alarm and Seconds Interrupt Generator

This block produces the two interrupt requests of a real-time clock. It does not keep time itself: the timekeeping logic presents the current seconds, minutes and hours as BCD bytes, the weekday as a code from 0 (Sunday) to 6, and a one-cycle pulse on each second boundary. The time inputs already show the new second in the cycle where the pulse is high.

The alarm source compares the programmed minute and hour against the running time, and checks whether the current weekday is selected in a seven-bit mask. The comparison is made only on the pulse that starts a new minute, which is the pulse where the seconds byte is 00, so the alarm resolves to the minute. The seconds source reacts to every pulse. Each source has its own enable bit in one control register, its own sticky pending flag, and its own level interrupt output. Software reaches the registers through a simple word write port and a registered read port.

Top module: `rtc_irq_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, both interrupt outputs are low and every register reads as zero.
- R2: Word 1 holds the alarm minute in its low 7 bits, word 2 the alarm hour in its low 6 bits, and word 3 the weekday mask in its low 7 bits. Bit n of the mask selects weekday code n, and 0 is Sunday. Unused bits read as zero. Read data appears one cycle after the read address is presented.
- R3: When alarm enable (word 0, bit 4) is set and a second pulse arrives with seconds 00, minute and hour equal to the alarm bytes, and the weekday bit set in the mask, irq_alarm goes high after that clock edge.
- R4: A mismatch of minute, hour or weekday mask bit stops the alarm. A weekday code of 7 never matches.
- R5: The alarm is evaluated only on a pulse with seconds 00. A pulse inside a matching minute at any other second does not raise it.
- R6: When seconds enable (word 0, bit 3) is set, every second pulse sets the seconds pending flag, and irq_sec goes high after that edge.
- R7: Each pending flag is sticky: the output stays high through later pulses and idle cycles until its enable bit is cleared. The output falls at the second edge after the write that clears the enable.
- R8: A pulse that arrives while a source's enable bit is clear is not remembered, so setting the enable afterwards does not raise the output.
- R9: Writing 0 to word 0 clears both enables, and both outputs are low from the second edge after the write.
- R10: Word 4 is read-only status, with bit 4 set for alarm pending and bit 3 set for seconds pending. Writes to it have no effect.
- R11: When both sources are enabled, a pulse at a matching minute boundary raises both outputs on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address for writes |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Register word address for reads |
| rd_data | output | DW | Read data, registered |
| sec_tick | input | 1 | One-cycle pulse at each second boundary |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, 24-hour |
| cur_wday | input | 3 | Current weekday code, 0 = Sunday |
| irq_alarm | output | 1 | Alarm interrupt level |
| irq_sec | output | 1 | Seconds interrupt level |

## Verification
The alarm and the seconds source both react to the same second pulse, and on a minute boundary that matches the alarm they must both set on the same edge. The bench provokes this by enabling both sources and then issuing one pulse with seconds 00 on a selected weekday. Both outputs are compared in the cycle after that edge, and the status word is compared one read later. The bench also checks the two sources apart, so that neither output can be passing only because it follows the other.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;
  localparam int BCDW = 8;
  localparam int WDW  = 3;
  localparam int NDAY = 7;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_AMIN  = 1;
  localparam int ADDR_AHOUR = 2;
  localparam int ADDR_AWDAY = 3;
  localparam int ADDR_STAT  = 4;

  localparam int BIT_ALM = 4;
  localparam int BIT_SEC = 3;

  localparam int NSRC    = 2;
  localparam int SRC_ALM = 0;
  localparam int SRC_SEC = 1;

  typedef struct packed {
    logic [NDAY-1:0] mask;
    logic [5:0]      hour;
    logic [6:0]      minute;
  } alarm_cfg_t;
endpackage

// File: rtl/rtcirq_regs.sv
module rtcirq_regs
  import rtcirq_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  input  logic [NSRC-1:0]     pend,
  output logic [NSRC-1:0]     src_en,
  output alarm_cfg_t          cfg,
  output logic [DW-1:0]       rd_data
);
  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en <= '0;
      cfg    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(ADDR_CTRL): begin
          src_en[SRC_ALM] <= wr_data[BIT_ALM];
          src_en[SRC_SEC] <= wr_data[BIT_SEC];
        end
        AW'(ADDR_AMIN):  cfg.minute <= wr_data[6:0];
        AW'(ADDR_AHOUR): cfg.hour   <= wr_data[5:0];
        AW'(ADDR_AWDAY): cfg.mask   <= wr_data[NDAY-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      AW'(ADDR_CTRL): begin
        rd_mux[BIT_ALM] = src_en[SRC_ALM];
        rd_mux[BIT_SEC] = src_en[SRC_SEC];
      end
      AW'(ADDR_AMIN):  rd_mux[6:0]      = cfg.minute;
      AW'(ADDR_AHOUR): rd_mux[5:0]      = cfg.hour;
      AW'(ADDR_AWDAY): rd_mux[NDAY-1:0] = cfg.mask;
      AW'(ADDR_STAT): begin
        rd_mux[BIT_ALM] = pend[SRC_ALM];
        rd_mux[BIT_SEC] = pend[SRC_SEC];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  a_r1_regs_reset: assert property (@(posedge clk) rst |=> (src_en == '0 && cfg == '0));
endmodule

// File: rtl/rtcirq_match.sv
module rtcirq_match
  import rtcirq_pkg::*;
(
  input  logic            sec_tick,
  input  logic [BCDW-1:0] cur_sec,
  input  logic [BCDW-1:0] cur_min,
  input  logic [BCDW-1:0] cur_hour,
  input  logic [WDW-1:0]  cur_wday,
  input  alarm_cfg_t      cfg,
  output logic            alarm_evt
);
  localparam int MASKW = 1 << WDW;

  logic [MASKW-1:0] mask_ext;
  logic             min_roll;
  logic             min_hit;
  logic             hour_hit;
  logic             day_hit;

  always_comb begin
    mask_ext = '0;
    mask_ext[NDAY-1:0] = cfg.mask;
    min_roll  = sec_tick && (cur_sec == '0);
    min_hit   = (cur_min  == BCDW'(cfg.minute));
    hour_hit  = (cur_hour == BCDW'(cfg.hour));
    day_hit   = mask_ext[cur_wday];
    alarm_evt = min_roll && min_hit && hour_hit && day_hit;
  end
endmodule

// File: rtl/rtcirq_sticky.sv
module rtcirq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic evt,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || !en) flag <= 1'b0;
    else if (evt)   flag <= 1'b1;
  end

  a_r8_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
    (!en && !flag) |=> !flag);
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
  import rtcirq_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic            sec_tick,
  input  logic [BCDW-1:0] cur_sec,
  input  logic [BCDW-1:0] cur_min,
  input  logic [BCDW-1:0] cur_hour,
  input  logic [WDW-1:0]  cur_wday,
  output logic            irq_alarm,
  output logic            irq_sec
);
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] src_evt;
  logic [NSRC-1:0] pend;
  alarm_cfg_t      cfg;
  logic            alarm_evt;

  rtcirq_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pend(pend), .src_en(src_en), .cfg(cfg), .rd_data(rd_data)
  );

  rtcirq_match u_match (
    .sec_tick(sec_tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_wday(cur_wday), .cfg(cfg), .alarm_evt(alarm_evt)
  );

  assign src_evt[SRC_ALM] = alarm_evt;
  assign src_evt[SRC_SEC] = sec_tick;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    rtcirq_sticky u_sticky (
      .clk(clk), .rst(rst), .en(src_en[g]), .evt(src_evt[g]), .flag(pend[g])
    );
  end

  assign irq_alarm = pend[SRC_ALM];
  assign irq_sec   = pend[SRC_SEC];

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == AW'(ADDR_CTRL));

  a_r5_alarm_at_rollover: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_alarm) |-> $past(sec_tick && cur_sec == '0));

  a_r4_bad_weekday: assert property (@(posedge clk) disable iff (rst)
    (cur_wday == 3'd7 && !irq_alarm) |=> !irq_alarm);

  a_r6_sec_from_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_sec) |-> $past(sec_tick));

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_alarm && !ctrl_wr && !$past(ctrl_wr)) |=> irq_alarm);

  a_r9_ctrl_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wr_data == '0) |=> ##1 (!irq_alarm && !irq_sec));

  a_r10_status: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == AW'(ADDR_STAT)) |=>
      (rd_data[BIT_ALM] == $past(irq_alarm) && rd_data[BIT_SEC] == $past(irq_sec)));
endmodule

// File: tb/sim_rtc_irq_gen.sv
module sim_rtc_irq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sec_tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
  logic [2:0] cur_wday = '0;
  logic       irq_alarm, irq_sec;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_irq_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
    .irq_alarm(irq_alarm), .irq_sec(irq_sec)
  );

  typedef struct {
    bit         use_rd;
    logic [7:0] rd;
    logic       ea;
    logic       es;
    string      tag;
  } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if (irq_alarm !== e.ea || irq_sec !== e.es ||
          (e.use_rd && rd_data !== e.rd)) begin
        n_bad++;
        $display("FAIL %s: alarm=%b sec=%b rd=%h, expected alarm=%b sec=%b rd=%h",
                 e.tag, irq_alarm, irq_sec, rd_data, e.ea, e.es,
                 e.use_rd ? e.rd : rd_data);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push(bit use_rd, logic [7:0] d, logic a, logic s, string tag);
    exp_t e;
    e.use_rd = use_rd; e.rd = d; e.ea = a; e.es = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_irq(logic a, logic s, string tag);
    push(1'b0, 8'h00, a, s, tag);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] d, logic ea, logic es, string tag);
    rd_addr = a;
    cyc();
    push(1'b1, d, ea, es, tag);
  endtask

  task automatic tick(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [2:0] w);
    cur_sec = s; cur_min = m; cur_hour = h; cur_wday = w; sec_tick = 1'b1;
    cyc();
    sec_tick = 1'b0;
  endtask

  initial begin
    repeat (4) cyc();
    expect_irq(1'b0, 1'b0, "R1 outputs in reset");
    rst = 1'b0;
    cyc();
    expect_irq(1'b0, 1'b0, "R1 outputs after reset");
    rd(3'd0, 8'h00, 1'b0, 1'b0, "R1 ctrl reset");
    rd(3'd1, 8'h00, 1'b0, 1'b0, "R1 minute reset");
    rd(3'd4, 8'h00, 1'b0, 1'b0, "R1 status reset");

    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    rd(3'd1, 8'h7F, 1'b0, 1'b0, "R2 minute width");
    rd(3'd2, 8'h3F, 1'b0, 1'b0, "R2 hour width");
    rd(3'd3, 8'h7F, 1'b0, 1'b0, "R2 mask width");
    wr(3'd1, 8'h30); wr(3'd2, 8'h12); wr(3'd3, 8'h22);
    rd(3'd1, 8'h30, 1'b0, 1'b0, "R2 minute readback");
    rd(3'd2, 8'h12, 1'b0, 1'b0, "R2 hour readback");
    rd(3'd3, 8'h22, 1'b0, 1'b0, "R2 mask readback");

    tick(8'h00, 8'h30, 8'h12, 3'd5);
    expect_irq(1'b0, 1'b0, "R8 match while disabled");
    wr(3'd0, 8'h10);
    expect_irq(1'b0, 1'b0, "R8 enable after missed match");
    rd(3'd0, 8'h10, 1'b0, 1'b0, "R2 ctrl readback");

    tick(8'h15, 8'h30, 8'h12, 3'd5);
    expect_irq(1'b0, 1'b0, "R5 mid-minute match");
    tick(8'h00, 8'h31, 8'h12, 3'd5);
    expect_irq(1'b0, 1'b0, "R4 minute mismatch");
    tick(8'h00, 8'h30, 8'h13, 3'd5);
    expect_irq(1'b0, 1'b0, "R4 hour mismatch");
    tick(8'h00, 8'h30, 8'h12, 3'd2);
    expect_irq(1'b0, 1'b0, "R4 weekday not in mask");
    wr(3'd3, 8'h7F);
    tick(8'h00, 8'h30, 8'h12, 3'd7);
    expect_irq(1'b0, 1'b0, "R4 weekday code 7");
    wr(3'd3, 8'h22);

    tick(8'h00, 8'h30, 8'h12, 3'd1);
    expect_irq(1'b1, 1'b0, "R3 alarm Monday");
    tick(8'h01, 8'h30, 8'h12, 3'd1);
    expect_irq(1'b1, 1'b0, "R7 held over next pulse");
    cyc();
    expect_irq(1'b1, 1'b0, "R7 held idle");
    rd(3'd4, 8'h10, 1'b1, 1'b0, "R10 status alarm");
    wr(3'd4, 8'h00);
    expect_irq(1'b1, 1'b0, "R10 status write ignored");
    rd(3'd4, 8'h10, 1'b1, 1'b0, "R10 status after write");
    wr(3'd0, 8'h00);
    expect_irq(1'b1, 1'b0, "R7 high one cycle after clear");
    cyc();
    expect_irq(1'b0, 1'b0, "R7 low after clear");

    wr(3'd0, 8'h10);
    tick(8'h00, 8'h30, 8'h12, 3'd5);
    expect_irq(1'b1, 1'b0, "R3 alarm Friday");
    wr(3'd0, 8'h00);
    cyc();

    tick(8'h07, 8'h02, 8'h03, 3'd0);
    expect_irq(1'b0, 1'b0, "R8 pulse while sec disabled");
    wr(3'd0, 8'h08);
    expect_irq(1'b0, 1'b0, "R8 sec enable no stale event");
    tick(8'h08, 8'h02, 8'h03, 3'd0);
    expect_irq(1'b0, 1'b1, "R6 first pulse");
    wr(3'd0, 8'h00);
    cyc();
    expect_irq(1'b0, 1'b0, "R7 sec cleared");
    wr(3'd0, 8'h08);
    tick(8'h09, 8'h02, 8'h03, 3'd0);
    expect_irq(1'b0, 1'b1, "R6 next pulse");
    rd(3'd4, 8'h08, 1'b0, 1'b1, "R10 status sec");

    wr(3'd0, 8'h00);
    cyc();
    wr(3'd0, 8'h18);
    expect_irq(1'b0, 1'b0, "R11 both armed idle");
    tick(8'h00, 8'h30, 8'h12, 3'd1);
    expect_irq(1'b1, 1'b1, "R11 both same edge");
    rd(3'd4, 8'h18, 1'b1, 1'b1, "R11 status both");
    wr(3'd0, 8'h00);
    expect_irq(1'b1, 1'b1, "R9 one cycle after zero write");
    cyc();
    expect_irq(1'b0, 1'b0, "R9 both cleared");
    rd(3'd0, 8'h00, 1'b0, 1'b0, "R9 ctrl zero");

    cyc(); cyc();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule